// File: doc/BRIEF.md
# Pipelined Sum-of-Absolute-Differences Unit

This block scores how well two image blocks match during motion estimation. The caller sends one pair of pixel rows per cycle, 16 unsigned 8-bit pixels per row, on a valid/ready handshake. The block adds the sum of absolute differences of each row pair to a running total. It does this for up to `h` rows of one block, where `h` is set at run time.

Each absolute difference is taken as the larger pixel minus the smaller one. The first stage only sorts each lane into a larger and a smaller value. The second stage adds the larger values and adds the bitwise complements of the smaller values, widened to the sum width. The third stage adds both partial sums to the total and adds one constant equal to the lane count. That constant turns the complements into negations, so the operation takes three register stages.

After each row has been added, the total is compared with a distance limit. When the total reaches or passes the limit, the block stops early, because the candidate position can no longer be the best one. A start pulse begins a block. A one-cycle done pulse ends it, and the caller then reads the sum and the early-stop flag.

Top module: `sad_unit`

## Requirements
- R1: While reset is held and in the cycle after it is released, `sum_o` is 0 and `done_o`, `early_stop_o` and `row_ready_o` are 0.
- R2: A `start_i` pulse clears the sum and the row counts, captures `rows_h_i` and `limit_i`, drops any row still in the pipeline, and clears `done_o` and `early_stop_o`.
- R3: `row_ready_o` is high only while a block is active and fewer than `rows_h_i` rows have been taken. A row is taken on a clock edge where `row_valid_i` and `row_ready_o` are both high.
- R4: Each taken row pair adds the sum over the 16 lanes of |A - B| to the total. Lane i occupies bits [8i+7:8i] of `row_a_i` and `row_b_i`, and pixels are unsigned. The total wraps modulo 2^16.
- R5: A row taken at clock edge k shows its contribution on `sum_o` after clock edge k+2, which is three register stages.
- R6: `done_o` is high for exactly one cycle, in the cycle after the h-th row has been added to the sum.
- R7: If the sum after a row has been added is greater than or equal to the captured limit, the block raises `early_stop_o` and pulses `done_o`, and it adds no further rows. `early_stop_o` stays high until the next start.
- R8: After done, `row_valid_i` and the row data have no effect: `row_ready_o` stays low and `sum_o` keeps its value until the next start.
- R9: A start with `rows_h_i` = 0 produces a done pulse one cycle after the start edge, with `sum_o` = 0 and no early stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new block |
| rows_h_i | input | 5 | Number of rows in the block (0 to 16), captured at start |
| limit_i | input | 16 | Distance limit for early stop, captured at start |
| row_valid_i | input | 1 | A row pair is presented |
| row_ready_o | output | 1 | The block will take the presented row pair |
| row_a_i | input | 128 | Current-frame row, 16 pixels of 8 bits |
| row_b_i | input | 128 | Reference row, 16 pixels of 8 bits |
| sum_o | output | 16 | Running and final sum of absolute differences |
| done_o | output | 1 | One-cycle pulse at the end of a block |
| early_stop_o | output | 1 | The block ended because the limit was reached |

## Verification
The assertions check on every cycle that done lasts a single cycle and that the early-stop flag holds until a new start. They also check that the flag rises only when the sum has reached the limit, that the total is frozen between blocks, and that the number of rows taken never exceeds h. Only the bench scenarios can show that the max-minus-min path with its complement correction gives the true absolute differences. They also show that contributions arrive with a three-cycle delay under gaps in the valid signal, and that early stop truncates the total at the correct row. The scenarios cover extreme pixel values with the smaller pixel in either input, and the empty block.

// File: rtl/sad_pkg.sv
package sad_pkg;

  parameter int unsigned PIX_W = 8;

  typedef logic [PIX_W-1:0] pix_t;

  // Larger of two unsigned pixels.
  function automatic pix_t pick_hi(input pix_t a, input pix_t b);
    return (a >= b) ? a : b;
  endfunction

  // Smaller of two unsigned pixels.
  function automatic pix_t pick_lo(input pix_t a, input pix_t b);
    return (a >= b) ? b : a;
  endfunction

endpackage

// File: rtl/sad_order.sv
// Stage 1: per-lane sort into larger and smaller pixel.
module sad_order
  import sad_pkg::*;
#(
  parameter int unsigned NPIX = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic                  take_i,
  input  logic [NPIX*PIX_W-1:0] row_a_i,
  input  logic [NPIX*PIX_W-1:0] row_b_i,
  output logic                  valid_o,
  output logic [NPIX*PIX_W-1:0] hi_o,
  output logic [NPIX*PIX_W-1:0] lo_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_o <= 1'b0;
    else if (flush_i)  valid_o <= 1'b0;
    else               valid_o <= take_i;
  end

  for (genvar l = 0; l < NPIX; l++) begin : g_lane
    pix_t a_l, b_l;
    assign a_l = row_a_i[l*PIX_W +: PIX_W];
    assign b_l = row_b_i[l*PIX_W +: PIX_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_o[l*PIX_W +: PIX_W] <= '0;
        lo_o[l*PIX_W +: PIX_W] <= '0;
      end else if (take_i) begin
        hi_o[l*PIX_W +: PIX_W] <= pick_hi(a_l, b_l);
        lo_o[l*PIX_W +: PIX_W] <= pick_lo(a_l, b_l);
      end
    end
  end

endmodule

// File: rtl/sad_fold.sv
// Stage 2: add the larger values, add the widened complements of the smaller ones.
module sad_fold
  import sad_pkg::*;
#(
  parameter int unsigned NPIX  = 16,
  parameter int unsigned SUM_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic                  valid_i,
  input  logic [NPIX*PIX_W-1:0] hi_i,
  input  logic [NPIX*PIX_W-1:0] lo_i,
  output logic                  valid_o,
  output logic [SUM_W-1:0]      hi_sum_o,
  output logic [SUM_W-1:0]      lo_cmp_sum_o
);

  logic [SUM_W-1:0] hi_acc [NPIX+1];
  logic [SUM_W-1:0] lo_acc [NPIX+1];

  assign hi_acc[0] = '0;
  assign lo_acc[0] = '0;

  for (genvar l = 0; l < NPIX; l++) begin : g_add
    logic [SUM_W-1:0] hi_w, lo_w;
    assign hi_w = SUM_W'(hi_i[l*PIX_W +: PIX_W]);
    assign lo_w = SUM_W'(lo_i[l*PIX_W +: PIX_W]);
    assign hi_acc[l+1] = hi_acc[l] + hi_w;
    assign lo_acc[l+1] = lo_acc[l] + ~lo_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o      <= 1'b0;
      hi_sum_o     <= '0;
      lo_cmp_sum_o <= '0;
    end else begin
      valid_o <= valid_i && !flush_i;
      if (valid_i) begin
        hi_sum_o     <= hi_acc[NPIX];
        lo_cmp_sum_o <= lo_acc[NPIX];
      end
    end
  end

  // R5: a valid stage-1 result always moves on to stage 2.
  a_r5_stage_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !flush_i) |=> valid_o);

endmodule

// File: rtl/sad_accum.sv
// Stage 3 plus block control: correction, accumulation, limit test, handshake.
module sad_accum #(
  parameter int unsigned NPIX     = 16,
  parameter int unsigned SUM_W    = 16,
  parameter int unsigned MAX_ROWS = 16,
  localparam int unsigned CW      = $clog2(MAX_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CW-1:0]    rows_h_i,
  input  logic [SUM_W-1:0] limit_i,
  input  logic             row_valid_i,
  input  logic             in_valid_i,
  input  logic [SUM_W-1:0] hi_sum_i,
  input  logic [SUM_W-1:0] lo_cmp_sum_i,
  output logic             ready_o,
  output logic             take_o,
  output logic [SUM_W-1:0] sum_o,
  output logic             done_o,
  output logic             early_o
);

  logic             active_q;
  logic [CW-1:0]    h_q, taken_q, added_q;
  logic [SUM_W-1:0] lim_q, acc_q;

  // Named internal events.
  logic             add_ev, hit_limit, last_row, empty_blk, finish;
  logic [SUM_W-1:0] contrib, acc_next;

  assign ready_o   = active_q && (taken_q < h_q);
  assign take_o    = ready_o && row_valid_i;
  assign contrib   = hi_sum_i + lo_cmp_sum_i + SUM_W'(NPIX);
  assign acc_next  = acc_q + contrib;
  assign add_ev    = active_q && in_valid_i;
  assign hit_limit = add_ev && (acc_next >= lim_q);
  assign last_row  = add_ev && ((added_q + CW'(1)) == h_q);
  assign empty_blk = active_q && (h_q == '0);
  assign finish    = hit_limit || last_row || empty_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      h_q      <= '0;
      lim_q    <= '0;
      taken_q  <= '0;
      added_q  <= '0;
      acc_q    <= '0;
      done_o   <= 1'b0;
      early_o  <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      h_q      <= rows_h_i;
      lim_q    <= limit_i;
      taken_q  <= '0;
      added_q  <= '0;
      acc_q    <= '0;
      done_o   <= 1'b0;
      early_o  <= 1'b0;
    end else begin
      done_o <= finish;
      if (take_o) taken_q <= taken_q + CW'(1);
      if (add_ev) begin
        acc_q   <= acc_next;
        added_q <= added_q + CW'(1);
      end
      if (hit_limit) early_o  <= 1'b1;
      if (finish)    active_q <= 1'b0;
    end
  end

  assign sum_o = acc_q;

  // R6: done never lasts two cycles.
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: rows taken never exceed the captured row count.
  a_r3_taken_bound: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= h_q);

  // R7: early stop is sticky until a new start.
  a_r7_early_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (early_o && !start_i) |=> early_o);

  // R7: early stop only rises with the sum at or above the limit.
  a_r7_early_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_o) |-> (acc_q >= lim_q));

  // R8: the total is frozen while no block is active.
  a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_i) |=> $stable(acc_q));

endmodule

// File: rtl/sad_unit.sv
module sad_unit
  import sad_pkg::*;
#(
  parameter int unsigned NPIX     = 16,
  parameter int unsigned SUM_W    = 16,
  parameter int unsigned MAX_ROWS = 16,
  localparam int unsigned CW      = $clog2(MAX_ROWS + 1),
  localparam int unsigned ROW_W   = NPIX * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CW-1:0]    rows_h_i,
  input  logic [SUM_W-1:0] limit_i,
  input  logic             row_valid_i,
  output logic             row_ready_o,
  input  logic [ROW_W-1:0] row_a_i,
  input  logic [ROW_W-1:0] row_b_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             done_o,
  output logic             early_stop_o
);

  logic             take;
  logic             s1_valid, s2_valid;
  logic [ROW_W-1:0] s1_hi, s1_lo;
  logic [SUM_W-1:0] s2_hi_sum, s2_lo_cmp;

  sad_order #(.NPIX(NPIX)) u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (start_i),
    .take_i  (take),
    .row_a_i (row_a_i),
    .row_b_i (row_b_i),
    .valid_o (s1_valid),
    .hi_o    (s1_hi),
    .lo_o    (s1_lo)
  );

  sad_fold #(.NPIX(NPIX), .SUM_W(SUM_W)) u_fold (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (start_i),
    .valid_i      (s1_valid),
    .hi_i         (s1_hi),
    .lo_i         (s1_lo),
    .valid_o      (s2_valid),
    .hi_sum_o     (s2_hi_sum),
    .lo_cmp_sum_o (s2_lo_cmp)
  );

  sad_accum #(.NPIX(NPIX), .SUM_W(SUM_W), .MAX_ROWS(MAX_ROWS)) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .rows_h_i     (rows_h_i),
    .limit_i      (limit_i),
    .row_valid_i  (row_valid_i),
    .in_valid_i   (s2_valid),
    .hi_sum_i     (s2_hi_sum),
    .lo_cmp_sum_i (s2_lo_cmp),
    .ready_o      (row_ready_o),
    .take_o       (take),
    .sum_o        (sum_o),
    .done_o       (done_o),
    .early_o      (early_stop_o)
  );

endmodule

// File: tb/sad_unit_tb.sv
`timescale 1ns/1ps
module sad_unit_tb_top;

  localparam int NPIX = 16;
  localparam int ROWW = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [4:0]      rows_h_i = '0;
  logic [15:0]     limit_i = '0;
  logic            row_valid_i = 1'b0;
  logic            row_ready_o;
  logic [ROWW-1:0] row_a_i = '0;
  logic [ROWW-1:0] row_b_i = '0;
  logic [15:0]     sum_o;
  logic            done_o;
  logic            early_stop_o;

  always #2 clk = ~clk;

  sad_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rows_h_i(rows_h_i),
    .limit_i(limit_i), .row_valid_i(row_valid_i), .row_ready_o(row_ready_o),
    .row_a_i(row_a_i), .row_b_i(row_b_i), .sum_o(sum_o), .done_o(done_o),
    .early_stop_o(early_stop_o)
  );

  int vectors = 0;
  int fails = 0;

  // Reference model state.
  bit m_active, m_done, m_early, m_p1, m_p2;
  int m_sum, m_h, m_lim, m_taken, m_added, m_c1, m_c2;
  bit pend_start, pend_take;
  int pend_contrib;

  logic [ROWW-1:0] blk_a [16];
  logic [ROWW-1:0] blk_b [16];

  // Reference row cost: subtraction followed by absolute value.
  function automatic int ref_cost(input logic [ROWW-1:0] a, input logic [ROWW-1:0] b);
    int s = 0;
    for (int i = 0; i < NPIX; i++) begin
      int d = int'(a[i*8 +: 8]) - int'(b[i*8 +: 8]);
      s += (d < 0) ? -d : d;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance the model by the clock edge that just passed.
  task automatic model_edge();
    bit fin = 0;
    if (pend_start) begin
      m_active = 1; m_h = rows_h_i; m_lim = limit_i;
      m_sum = 0; m_taken = 0; m_added = 0;
      m_done = 0; m_early = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      if (m_active && m_h == 0) fin = 1;
      if (m_active && m_p2) begin
        m_sum = (m_sum + m_c2) & 16'hFFFF;
        m_added++;
        if (m_sum >= m_lim) begin m_early = 1; fin = 1; end
        else if (m_added == m_h) fin = 1;
      end
      if (pend_take) m_taken++;
      if (fin) m_active = 0;
      m_done = fin;
      m_p2 = m_p1; m_c2 = m_c1;
      m_p1 = pend_take; m_c1 = pend_contrib;
    end
  endtask

  task automatic compare_all();
    bit exp_rdy = m_active && (m_taken < m_h);
    check(sum_o == 16'(m_sum), "R5 sum timing", sum_o, m_sum);
    check(done_o == m_done, "R6 done", done_o, m_done);
    check(early_stop_o == m_early, "R7 early flag", early_stop_o, m_early);
    check(row_ready_o == exp_rdy, "R3 ready", row_ready_o, exp_rdy);
  endtask

  // Drive one cycle at a falling edge, then step to the next falling edge.
  task automatic drive(input bit st, input bit vld, input int idx);
    start_i = st;
    row_valid_i = vld;
    row_a_i = blk_a[idx[3:0]];
    row_b_i = blk_b[idx[3:0]];
    pend_start = st;
    pend_take = vld && row_ready_o && !st;
    pend_contrib = ref_cost(row_a_i, row_b_i);
    @(negedge clk);
    model_edge();
    compare_all();
  endtask

  // kind: 0 random, 1 A=255/B=0, 2 A=0/B=255, 3 equal rows. gaps: random valid.
  task automatic run_block(input int h, input int lim, input int kind, input bit gaps);
    int idx = 0;
    int exp_total = 0;
    bit exp_early = 0;
    int cyc = 0;
    bit seen_done = 0;
    int held;
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < NPIX; i++) begin
        case (kind)
          1: begin blk_a[r][i*8 +: 8] = 8'hFF; blk_b[r][i*8 +: 8] = 8'h00; end
          2: begin blk_a[r][i*8 +: 8] = 8'h00; blk_b[r][i*8 +: 8] = 8'hFF; end
          3: begin blk_a[r][i*8 +: 8] = 8'($urandom); blk_b[r][i*8 +: 8] = blk_a[r][i*8 +: 8]; end
          default: begin blk_a[r][i*8 +: 8] = 8'($urandom); blk_b[r][i*8 +: 8] = 8'($urandom); end
        endcase
      end
    end
    for (int r = 0; r < h; r++) begin
      if (!exp_early) begin
        exp_total = (exp_total + ref_cost(blk_a[r], blk_b[r])) & 16'hFFFF;
        if (exp_total >= lim) exp_early = 1;
      end
    end
    rows_h_i = 5'(h);
    limit_i = 16'(lim);
    drive(1, 0, 0);
    while (!seen_done && cyc < 300) begin
      bit v = gaps ? bit'($urandom_range(0, 1)) : 1'b1;
      bit tk = v && row_ready_o;
      drive(0, v, idx);
      if (tk) idx++;
      if (done_o) seen_done = 1;
      cyc++;
    end
    check(seen_done, "R6 done reached (watchdog)", seen_done, 1);
    // R4/R7: final result against an independent running total.
    check(sum_o == 16'(exp_total), "R4 final sum", sum_o, exp_total);
    check(early_stop_o == exp_early, "R7 early result", early_stop_o, exp_early);
    // R8: inputs after done are ignored.
    held = sum_o;
    for (int k = 0; k < 4; k++) drive(0, 1, k);
    check(sum_o == 16'(held), "R8 sum held after done", sum_o, held);
    check(row_ready_o == 1'b0, "R8 ready low after done", row_ready_o, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) begin blk_a[r] = '0; blk_b[r] = '0; end
    m_active = 0; m_done = 0; m_early = 0; m_p1 = 0; m_p2 = 0;
    m_sum = 0; m_h = 0; m_lim = 0; m_taken = 0; m_added = 0; m_c1 = 0; m_c2 = 0;
    repeat (3) @(negedge clk);
    // R1: values while in reset.
    check(sum_o == 0 && done_o == 0 && early_stop_o == 0 && row_ready_o == 0,
          "R1 reset state", {sum_o, done_o, early_stop_o, row_ready_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sum_o == 0 && done_o == 0 && early_stop_o == 0 && row_ready_o == 0,
          "R1 after release", {sum_o, done_o, early_stop_o, row_ready_o}, 0);

    run_block(4, 16'hFFFF, 0, 0);      // R4 plain block
    run_block(16, 16'hFFFF, 0, 1);     // R5 with valid gaps
    run_block(16, 16'hFFFF, 1, 0);     // R4 extreme, smaller pixel in B
    run_block(16, 16'hFFFF, 2, 1);     // R4 extreme, smaller pixel in A
    run_block(8, 16'hFFFF, 3, 0);      // R4 identical rows
    run_block(16, 5000, 0, 0);         // R7 mid-block early stop
    run_block(10, 0, 0, 1);            // R7 limit zero stops after first row
    run_block(16, 4080, 1, 0);         // R7 equality hits limit exactly
    run_block(0, 100, 0, 0);           // R9 empty block
    check(sum_o == 0 && early_stop_o == 0, "R9 empty block result", sum_o, 0);

    // R2: restart while a block is in flight drops pending rows.
    for (int t = 0; t < 6; t++) run_block(1 + t * 3, (t % 2) ? 3000 : 16'hFFFF, 0, 1);
    rows_h_i = 5'd16; limit_i = 16'hFFFF;
    drive(1, 0, 0);
    for (int k = 0; k < 3; k++) drive(0, 1, k);
    run_block(3, 16'hFFFF, 0, 0);      // R2 fresh block after interrupt

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule